// File: doc/BRIEF.md
# Serial Interrupt Bus Host

This block is the host end of a shared, single-wire, open-drain interrupt bus that runs off the PCI clock. The host begins each bus cycle with a start frame. It then steps through a series of three-clock data frames. In the first clock of each frame it samples the wire and turns the level into one interrupt bit, applying the polarity that belongs to that frame slot. After the last data frame it drives a stop frame. The stop frame is two or three clocks long, and its width sets the mode for the next cycle.

In quiet mode any device on the bus may begin a cycle by pulling the idle wire low. The host sees this and continues it as its own start frame. In continuous mode only the host starts cycles, on a request pulse. The output is a vector of interrupt levels, one per frame slot, where 1 always means "asserted". Three of the slots (0, 8 and 13) come from sources inside the chip, so the host never updates those bits from the wire.

The sequencer states are: IDLE (wire released), START_LO (host drives low), START_HI (host drives high for one clock), FRAME (wire released, phase 0/1/2), STOP_LO (host drives low) and STOP_HI (host drives high for one clock). The transitions are:
- IDLE to START_LO on a start request, or in quiet mode on a low wire.
- START_LO to START_HI after the configured length.
- START_HI to FRAME.
- FRAME to STOP_LO after phase 2 of the last frame.
- STOP_LO to STOP_HI after two or three clocks.
- STOP_HI to IDLE.

Top module: `sirq_host`

## Requirements
- R1: While reset is held and after it, `line_oe` is 0, `irq_lvl` is all zeros and `mode_cont` is 1. The bus starts in continuous mode.
- R2: A start frame drives the wire low (`line_oe`=1, `line_out`=0) for 4, 6 or 8 clocks when `cfg_start_len` is 0, 1 or 2/3. It then drives high for exactly one clock. The wire is then released.
- R3: Every data frame lasts 3 clocks with `line_oe`=0. Frame k's sample clock is the (L+1+3k)-th clock after the start frame begins, counting from 0, where L is the start length.
- R4: For frames 0–15 (ISA slots), a high wire at the sample clock sets the slot's output to 1 and a low wire sets it to 0.
- R5: For frames 16–21 (IOCHK, INTA, INTB, INTC, INTD, SMI in that order), a low wire at the sample clock sets the output to 1 and a high wire sets it to 0.
- R6: Outputs for frames 0, 8 and 13 stay 0 whatever the wire does in those frames.
- R7: `cfg_frames` sets the number of data frames, clamped to the range 1..22 (0 acts as 1). Slots at or above that count keep their previous values.
- R8: After the last frame the host drives low for 2 clocks (`cfg_long_stop`=0) or 3 clocks (`cfg_long_stop`=1). It then drives high for one clock and releases the wire.
- R9: `mode_cont` takes the value of `cfg_long_stop` on the clock after the last stop-low clock. The value 0 means quiet mode and 1 means continuous mode. It changes at no other time.
- R10: In quiet mode, a low wire seen in IDLE starts the start frame on the next clock. In continuous mode a low idle wire has no effect.
- R11: `start_req` seen in IDLE starts the start frame on the next clock. Outside IDLE it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sampled level of the shared wire |
| line_oe | output | 1 | Host drives the wire when 1 |
| line_out | output | 1 | Level the host drives when `line_oe` is 1 |
| start_req | input | 1 | Request to begin a bus cycle |
| cfg_start_len | input | 2 | Start-frame low length select (0:4, 1:6, 2/3:8) |
| cfg_long_stop | input | 1 | 1: 3-clock stop (continuous), 0: 2-clock stop (quiet) |
| cfg_frames | input | 5 | Number of data frames, clamped to 1..22 |
| irq_lvl | output | 22 | Polarity-corrected interrupt levels, one per frame slot |
| mode_cont | output | 1 | Current mode, 1 = continuous |

## Verification
Two inputs can meet in the same IDLE clock: a host `start_req` and a device pulling the wire low in quiet mode. The bench raises both on the same clock and expects exactly one start frame of the configured length. A `start_req` pulse that arrives in the middle of a cycle must not start a second cycle. The bench's clock-level model follows each cycle position and the sample it expects. It compares drive, levels and mode against the design on every clock, so a doubled, shortened or missing frame shows up on the first clock where they differ.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_START_LO = 3'd1,
        ST_START_HI = 3'd2,
        ST_FRAME    = 3'd3,
        ST_STOP_LO  = 3'd4,
        ST_STOP_HI  = 3'd5
    } sirq_state_e;

    localparam int ISA_SLOTS = 16;

    // Slots whose sources live inside the chip; the wire never updates them.
    function automatic bit slot_ignored(input int idx);
        return (idx == 0) || (idx == 8) || (idx == 13);
    endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 22,
    parameter int IDX_W      = $clog2(MAX_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             start_req,
    input  logic [1:0]       cfg_start_len,
    input  logic             cfg_long_stop,
    input  logic [IDX_W-1:0] cfg_frames,
    output sirq_state_e      state,
    output logic [IDX_W-1:0] frame_idx,
    output logic             sample_stb,
    output logic             mode_cont
);

    localparam int CNT_W = 3;

    sirq_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [1:0]       phase_q, phase_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             mode_q, mode_n;
    logic [CNT_W-1:0] start_last;
    logic [CNT_W-1:0] stop_last;
    logic [IDX_W-1:0] frames_eff;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        unique case (cfg_start_len)
            2'd0:    start_last = CNT_W'(3);
            2'd1:    start_last = CNT_W'(5);
            default: start_last = CNT_W'(7);
        endcase
        stop_last = cfg_long_stop ? CNT_W'(2) : CNT_W'(1);
        if (cfg_frames == '0)
            frames_eff = IDX_W'(1);
        else if (cfg_frames > IDX_W'(MAX_FRAMES))
            frames_eff = IDX_W'(MAX_FRAMES);
        else
            frames_eff = cfg_frames;
        last_idx = frames_eff - IDX_W'(1);
    end

    // Next-state process
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        phase_n = phase_q;
        idx_n   = idx_q;
        mode_n  = mode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req || (!mode_q && !line_in)) begin
                    state_n = ST_START_LO;
                    cnt_n   = '0;
                end
            end
            ST_START_LO: begin
                if (cnt_q == start_last) state_n = ST_START_HI;
                else                     cnt_n   = cnt_q + CNT_W'(1);
            end
            ST_START_HI: begin
                state_n = ST_FRAME;
                phase_n = '0;
                idx_n   = '0;
            end
            ST_FRAME: begin
                if (phase_q == 2'd2) begin
                    phase_n = '0;
                    if (idx_q == last_idx) begin
                        state_n = ST_STOP_LO;
                        cnt_n   = '0;
                    end else begin
                        idx_n = idx_q + IDX_W'(1);
                    end
                end else begin
                    phase_n = phase_q + 2'd1;
                end
            end
            ST_STOP_LO: begin
                if (cnt_q == stop_last) begin
                    state_n = ST_STOP_HI;
                    mode_n  = cfg_long_stop;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_STOP_HI: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            phase_q <= '0;
            idx_q   <= '0;
            mode_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            phase_q <= phase_n;
            idx_q   <= idx_n;
            mode_q  <= mode_n;
        end
    end

    assign state      = state_q;
    assign frame_idx  = idx_q;
    assign sample_stb = (state_q == ST_FRAME) && (phase_q == 2'd0);
    assign mode_cont  = mode_q;

    assert_start_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START_HI) |-> ($past(state_q) == ST_START_LO));

    assert_frame_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME) |-> (idx_q < frames_eff));

    assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP_HI) |=> (state_q == ST_IDLE));

    assert_mode_only_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> ($past(state_q) == ST_STOP_LO));

    assert_cont_ignores_wire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mode_q && !start_req) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sirq_drive.sv
module sirq_drive
    import sirq_pkg::*;
(
    input  sirq_state_e state,
    output logic        line_oe,
    output logic        line_out
);

    // Output process
    always_comb begin
        unique case (state)
            ST_START_LO, ST_STOP_LO: begin
                line_oe  = 1'b1;
                line_out = 1'b0;
            end
            ST_START_HI, ST_STOP_HI: begin
                line_oe  = 1'b1;
                line_out = 1'b1;
            end
            default: begin
                line_oe  = 1'b0;
                line_out = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 22,
    parameter int IDX_W      = $clog2(MAX_FRAMES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_stb,
    input  logic [IDX_W-1:0]      frame_idx,
    input  logic                  line_in,
    output logic [MAX_FRAMES-1:0] irq_lvl
);

    for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_slot
        if (slot_ignored(g)) begin : g_fixed
            assign irq_lvl[g] = 1'b0;
        end else begin : g_live
            logic lvl_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lvl_q <= 1'b0;
                else if (sample_stb && frame_idx == IDX_W'(g))
                    lvl_q <= (g < ISA_SLOTS) ? line_in : ~line_in;
            end
            assign irq_lvl[g] = lvl_q;
        end
    end

    logic ign_hit;
    assign ign_hit = sample_stb &&
                     (frame_idx == IDX_W'(0) || frame_idx == IDX_W'(8) ||
                      frame_idx == IDX_W'(13));

    assert_ignored_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ign_hit |=> $stable(irq_lvl));

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 22,
    parameter int IDX_W      = $clog2(MAX_FRAMES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    output logic                  line_oe,
    output logic                  line_out,
    input  logic                  start_req,
    input  logic [1:0]            cfg_start_len,
    input  logic                  cfg_long_stop,
    input  logic [IDX_W-1:0]      cfg_frames,
    output logic [MAX_FRAMES-1:0] irq_lvl,
    output logic                  mode_cont
);

    sirq_state_e      state;
    logic [IDX_W-1:0] frame_idx;
    logic             sample_stb;

    sirq_seq #(.MAX_FRAMES(MAX_FRAMES), .IDX_W(IDX_W)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .start_req     (start_req),
        .cfg_start_len (cfg_start_len),
        .cfg_long_stop (cfg_long_stop),
        .cfg_frames    (cfg_frames),
        .state         (state),
        .frame_idx     (frame_idx),
        .sample_stb    (sample_stb),
        .mode_cont     (mode_cont)
    );

    sirq_drive drive_i (
        .state    (state),
        .line_oe  (line_oe),
        .line_out (line_out)
    );

    sirq_decode #(.MAX_FRAMES(MAX_FRAMES), .IDX_W(IDX_W)) decode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .frame_idx  (frame_idx),
        .line_in    (line_in),
        .irq_lvl    (irq_lvl)
    );

    assert_reset_released_R1: assert property (@(posedge clk)
        !rst_n |=> !line_oe);

endmodule

// File: tb/sirq_host_tb.sv
module sirq_host_tb_top;

    localparam int NF = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_r = 1'b1;
    logic          line_oe, line_out;
    logic          start_req = 1'b0;
    logic [1:0]    cfg_start_len = 2'd0;
    logic          cfg_long_stop = 1'b0;
    logic [4:0]    cfg_frames = 5'd22;
    logic [NF-1:0] irq_lvl;
    logic          mode_cont;

    logic          idle_pull = 1'b0;
    logic [NF-1:0] pat = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sirq_host dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_r), .line_oe(line_oe),
        .line_out(line_out), .start_req(start_req), .cfg_start_len(cfg_start_len),
        .cfg_long_stop(cfg_long_stop), .cfg_frames(cfg_frames),
        .irq_lvl(irq_lvl), .mode_cont(mode_cont)
    );

    // ---------------- reference model ----------------
    bit            m_busy;
    int            m_pos;
    bit            m_mode;
    logic [NF-1:0] m_irq;

    function automatic int len_start();
        return (cfg_start_len == 2'd0) ? 4 : (cfg_start_len == 2'd1) ? 6 : 8;
    endfunction
    function automatic int n_frames();
        int n = int'(cfg_frames);
        if (n < 1) n = 1;
        if (n > NF) n = NF;
        return n;
    endfunction
    function automatic int len_stop();
        return cfg_long_stop ? 3 : 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pos = 0; m_mode = 1; m_irq = '0;
        end else if (!m_busy) begin
            if (start_req || (!m_mode && !line_r)) begin
                m_busy = 1; m_pos = 0;
            end
        end else begin
            int d;
            int k;
            int data_end;
            d = m_pos - (len_start() + 1);
            data_end = len_start() + 1 + 3 * n_frames();
            if (d >= 0 && d < 3 * n_frames() && d % 3 == 0) begin
                k = d / 3;
                if (!(k == 0 || k == 8 || k == 13))
                    m_irq[k] = (k < 16) ? line_r : !line_r;
            end
            if (m_pos == data_end + len_stop() - 1) m_mode = cfg_long_stop;
            if (m_pos == data_end + len_stop()) m_busy = 0;
            else m_pos = m_pos + 1;
        end
    end

    function automatic string m_region();
        int data_end = len_start() + 1 + 3 * n_frames();
        if (!m_busy) return "R11";
        if (m_pos <= len_start()) return "R2";
        if (m_pos < data_end) return "R3";
        return "R8";
    endfunction

    task automatic exp_drive(output bit oe, output bit out);
        int data_end = len_start() + 1 + 3 * n_frames();
        oe = 1; out = 1;
        if (!m_busy) begin oe = 0; end
        else if (m_pos < len_start()) out = 0;
        else if (m_pos == len_start()) out = 1;
        else if (m_pos < data_end) oe = 0;
        else if (m_pos < data_end + len_stop()) out = 0;
        else out = 1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Per-clock comparison and wire resolution, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            bit eo, eout;
            bit pull;
            int d;
            exp_drive(eo, eout);
            check(line_oe == eo, m_region(), "line_oe", line_oe, eo);
            if (eo) check(line_out == eout, m_region(), "line_out", line_out, eout);
            check(irq_lvl == m_irq, "R7", "irq_lvl", irq_lvl, m_irq);
            check(mode_cont == m_mode, "R9", "mode_cont", mode_cont, m_mode);
            pull = 0;
            d = m_pos - (len_start() + 1);
            if (!m_busy) pull = idle_pull;
            else if (d >= 0 && d < 3 * n_frames() && d % 3 == 0) pull = pat[d / 3];
            line_r = line_oe ? line_out : !pull;
        end else begin
            line_r = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL R11 watchdog expired actual=%0d expected<%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [NF-1:0] predict(input logic [NF-1:0] prev,
                                              input logic [NF-1:0] p, input int n);
        logic [NF-1:0] v = prev;
        for (int k = 0; k < n; k++)
            if (!(k == 0 || k == 8 || k == 13)) v[k] = (k < 16) ? !p[k] : p[k];
        return v;
    endfunction

    task automatic wait_cycle_done();
        while (!m_busy) @(negedge clk);
        #1 start_req = 0; idle_pull = 0;
        while (m_busy) @(negedge clk);
        #1;
    endtask

    initial begin
        logic [NF-1:0] expv;
        repeat (3) @(negedge clk);
        #3;
        check(line_oe == 0, "R1", "reset oe", line_oe, 0);
        check(irq_lvl == '0, "R1", "reset irq", irq_lvl, 0);
        check(mode_cont == 1, "R1", "reset mode", mode_cont, 1);
        @(negedge clk); #1 rst_n = 1;
        repeat (3) @(negedge clk);

        // Continuous mode from reset: host request, 4-clock start, all-high wire
        #1 cfg_start_len = 0; cfg_long_stop = 0; cfg_frames = 22; pat = '0;
        expv = predict(irq_lvl, pat, 22);
        start_req = 1;
        @(negedge clk); wait_cycle_done();
        check(irq_lvl == expv, "R4", "ISA high levels", irq_lvl, expv);
        check(irq_lvl[0] == 0 && irq_lvl[8] == 0 && irq_lvl[13] == 0, "R6", "ignored slots",
              {irq_lvl[13], irq_lvl[8], irq_lvl[0]}, 0);
        check(mode_cont == 0, "R9", "quiet after 2-clock stop", mode_cont, 0);
        repeat (3) @(negedge clk);

        // Quiet mode: device starts the cycle, 6-clock start, 3-clock stop
        #1 cfg_start_len = 1; cfg_long_stop = 1; pat = 22'h2A5A5A;
        expv = predict(irq_lvl, pat, 22);
        idle_pull = 1;
        @(negedge clk); wait_cycle_done();
        check(irq_lvl == expv, "R5", "mixed polarity levels", irq_lvl, expv);
        check(mode_cont == 1, "R9", "continuous after 3-clock stop", mode_cont, 1);

        // Continuous: a low idle wire must be ignored
        @(negedge clk); #1 idle_pull = 1;
        repeat (10) @(negedge clk);
        #3 check(line_oe == 0, "R10", "no start on idle low in continuous", line_oe, 0);
        #1 idle_pull = 0;
        repeat (2) @(negedge clk);

        // Short frame count, 8-clock start; upper slots must hold
        #1 cfg_start_len = 2; cfg_long_stop = 0; cfg_frames = 5; pat = 22'h3FFFFF;
        expv = predict(irq_lvl, pat, 5);
        start_req = 1;
        @(negedge clk); wait_cycle_done();
        check(irq_lvl == expv, "R7", "upper slots held", irq_lvl, expv);

        // Quiet: request and device pull on the same clock, frames=0 clamps to 1
        repeat (2) @(negedge clk);
        #1 cfg_start_len = 3; cfg_frames = 0; pat = '0;
        start_req = 1; idle_pull = 1;
        @(negedge clk); wait_cycle_done();
        check(mode_cont == 0, "R10", "quiet kept", mode_cont, 0);

        // Request pulse mid-cycle must not start a second cycle
        repeat (2) @(negedge clk);
        #1 cfg_start_len = 0; cfg_frames = 22; pat = 22'h155555;
        expv = predict(irq_lvl, pat, 22);
        start_req = 1;
        @(negedge clk);
        while (!m_busy) @(negedge clk);
        #1 start_req = 0;
        repeat (20) @(negedge clk);
        #1 start_req = 1;
        @(negedge clk); #1 start_req = 0;
        while (m_busy) @(negedge clk);
        repeat (6) @(negedge clk);
        #3 check(line_oe == 0, "R11", "no restart from mid-cycle request", line_oe, 0);
        check(irq_lvl == expv, "R4", "alternating levels", irq_lvl, expv);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule